// File: doc/BRIEF.md
# Protocol-Partitioned Address-Prefix Rule Matcher

This block classifies a packet header by its addresses. A lookup presents a protocol code, a 32-bit source address and a 32-bit destination address. Every protocol code owns three small tables: a source prefix table, a destination prefix table and a rule table. A rule names one source-table slot and one destination-table slot. It fires only when both referenced prefixes contain the packet's addresses. The block then streams out the rule ID of every firing rule, one per clock, and marks the end of the lookup with a single done pulse.

Lookups run in two passes over the selected protocol's tables. The first pass walks the source and destination prefix tables together, one slot per clock, and records a hit bit for each slot. The second pass walks the rule table, one slot per clock, and tests each rule's pair of references against those hit bits. All tables are filled through one write port. Writes are applied while the block is idle. A single host address is stored as a full-length prefix.

Top module: `cidr_rule_matcher`

## Requirements
- R1: After reset, lkReady is 1 and both resValid and lkDone are 0. Every table slot counts as empty until it is written.
- R2: A prefix slot hits when the address and the stored base agree in their top L bits, where L is the stored length. L = 0 hits every address. Any L of 32 or more requires all 32 bits to agree.
- R3: Valid protocol codes are 1, 2, 3 and 4 (UDP, TCP, ICMP, IP). Each code reads only its own three tables, so entries loaded under one code never affect a lookup under another.
- R4: A rule fires only when its referenced source slot and its referenced destination slot both hit. A slot that was never written never hits.
- R5: A rule word is laid out as [47:32] rule ID, [31:16] source slot index and [15:0] destination slot index. A rule whose source or destination index is 16 or larger never fires.
- R6: The write port selects the table with wrTable (0 = source prefix, 1 = destination prefix, 2 = rule), the protocol with wrProto and the slot with wrIdx. A prefix word is laid out as [47:16] base address and [15:0] prefix length.
- R7: The start edge is edge 0 of a lookup with a valid code. The result for rule slot j appears after edge 17+j, in rising slot order, with resValid high for exactly that cycle. lkDone is high for the single cycle after edge 32. lkReady returns after edge 33.
- R8: A lookup with a code outside 1..4 raises lkDone right after the start edge, produces no resValid, and lkReady returns one cycle later.
- R9: lkStart is ignored while a lookup is in progress. It changes neither that lookup's results nor its timing, and it starts no further lookup.
- R10: A write with a protocol code outside 1..4, or with wrTable = 3, changes no table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Table write strobe |
| wrTable | input | 2 | Table select: 0 source, 1 destination, 2 rule |
| wrProto | input | 8 | Protocol code of the written table |
| wrIdx | input | 4 | Slot index within the table |
| wrData | input | 48 | Prefix word or rule word |
| lkStart | input | 1 | Start a lookup, taken while lkReady is high |
| lkProto | input | 8 | Protocol code of the lookup |
| lkSrcAddr | input | 32 | Packet source address |
| lkDstAddr | input | 32 | Packet destination address |
| lkReady | output | 1 | Idle and able to take lkStart |
| resValid | output | 1 | resId carries a firing rule ID |
| resId | output | 16 | Rule ID of a firing rule |
| lkDone | output | 1 | One-cycle pulse that ends a lookup |

## Verification
The bench uses several kinds of prefix in one table: prefix lengths of 0, 1, 8, 12, 24, 31, 32 and an oversized 40. A mask built off by one, or a wrong handling of length 0 or of long lengths, adds or drops rule IDs. Some rules point at unwritten slots or at out-of-range indices. A matcher that ignores the empty flags or truncates the indices would report those rules. The same address tuple is run under different protocol codes, and writes are made with code 0, code 5 and table select 3. A decoder that wraps or aliases these codes would leak entries into another protocol's tables. A second start is pulsed in mid-lookup; a block that took it would restart or shift its result cycles.

// File: rtl/cidr_match_pkg.sv
package cidr_match_pkg;

  localparam int ADDR_W  = 32;
  localparam int LEN_W   = 16;
  localparam int ID_W    = 16;
  localparam int REF_W   = 16;
  localparam int PROTO_W = 8;
  localparam int WORD_W  = ADDR_W + LEN_W;
  localparam int RULE_W  = ID_W + 2 * REF_W;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PFX  = 2'd1,
    ST_RULE = 2'd2,
    ST_FIN  = 2'd3
  } lkState_t;

  typedef struct packed {
    logic capture;
    logic pfxScan;
    logic ruleScan;
  } ctrlStrobes_t;

  // top L bits of addr must equal those of base; L >= ADDR_W means all bits
  function automatic logic prefixHit(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [LEN_W-1:0]  len);
    logic [ADDR_W-1:0] mask;
    if (len >= LEN_W'(ADDR_W)) mask = {ADDR_W{1'b1}};
    else                       mask = ~({ADDR_W{1'b1}} >> len);
    return ((addr ^ base) & mask) == '0;
  endfunction

endpackage

// File: rtl/cidr_match_ctrl.sv
module cidr_match_ctrl
  import cidr_match_pkg::*;
#(
  parameter int NUM_PROTO = 4,
  parameter int ENTRIES   = 16,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lkStart,
  input  logic [PROTO_W-1:0] lkProto,
  output ctrlStrobes_t       strobes,
  output logic [IDX_W-1:0]   scanIdx,
  output logic               lkReady,
  output logic               lkDone
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  lkState_t state;
  logic     protoOk;

  assign protoOk = (lkProto >= PROTO_W'(1)) && (lkProto <= PROTO_W'(NUM_PROTO));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      scanIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (lkStart) begin
            scanIdx <= '0;
            state   <= protoOk ? ST_PFX : ST_FIN;
          end
        end
        ST_PFX: begin
          if (scanIdx == LAST_IDX) begin
            scanIdx <= '0;
            state   <= ST_RULE;
          end else begin
            scanIdx <= scanIdx + 1'b1;
          end
        end
        ST_RULE: begin
          if (scanIdx == LAST_IDX) begin
            scanIdx <= '0;
            state   <= ST_FIN;
          end else begin
            scanIdx <= scanIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.capture  = (state == ST_IDLE) && lkStart;
    strobes.pfxScan  = (state == ST_PFX);
    strobes.ruleScan = (state == ST_RULE);
  end

  assign lkReady = (state == ST_IDLE);
  assign lkDone  = (state == ST_FIN);

endmodule

// File: rtl/cidr_match_dp.sv
module cidr_match_dp
  import cidr_match_pkg::*;
#(
  parameter int NUM_PROTO = 4,
  parameter int ENTRIES   = 16,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int PSEL_W   = (NUM_PROTO > 1) ? $clog2(NUM_PROTO) : 1,
  localparam int SLOTS    = NUM_PROTO * ENTRIES,
  localparam int SLOT_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         wrTable,
  input  logic [PROTO_W-1:0] wrProto,
  input  logic [IDX_W-1:0]   wrIdx,
  input  logic [WORD_W-1:0]  wrData,
  input  logic [PROTO_W-1:0] lkProto,
  input  logic [ADDR_W-1:0]  lkSrcAddr,
  input  logic [ADDR_W-1:0]  lkDstAddr,
  input  ctrlStrobes_t       strobes,
  input  logic [IDX_W-1:0]   scanIdx,
  output logic               resValid,
  output logic [ID_W-1:0]    resId
);

  logic [WORD_W-1:0] srcTab  [SLOTS];
  logic [WORD_W-1:0] dstTab  [SLOTS];
  logic [RULE_W-1:0] ruleTab [SLOTS];
  logic [SLOTS-1:0]  srcUsed, dstUsed, ruleUsed;

  logic [PSEL_W-1:0] capSel;
  logic [ADDR_W-1:0] capSrc, capDst;
  logic [ENTRIES-1:0] srcHit, dstHit;

  // write decode
  logic              wrProtoOk;
  logic [SLOT_W-1:0] wrSlot;
  logic              wrSrc, wrDst, wrRule;

  assign wrProtoOk = (wrProto >= PROTO_W'(1)) && (wrProto <= PROTO_W'(NUM_PROTO));
  assign wrSlot    = SLOT_W'(32'(wrProto - PROTO_W'(1)) * ENTRIES + 32'(wrIdx));
  assign wrSrc     = wrEn && wrProtoOk && (wrTable == 2'd0);
  assign wrDst     = wrEn && wrProtoOk && (wrTable == 2'd1);
  assign wrRule    = wrEn && wrProtoOk && (wrTable == 2'd2);

  always_ff @(posedge clk) begin
    if (wrSrc)  srcTab[wrSlot]  <= wrData;
    if (wrDst)  dstTab[wrSlot]  <= wrData;
    if (wrRule) ruleTab[wrSlot] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcUsed  <= '0;
      dstUsed  <= '0;
      ruleUsed <= '0;
    end else begin
      if (wrSrc)  srcUsed[wrSlot]  <= 1'b1;
      if (wrDst)  dstUsed[wrSlot]  <= 1'b1;
      if (wrRule) ruleUsed[wrSlot] <= 1'b1;
    end
  end

  // read side
  logic [SLOT_W-1:0] rdSlot;
  logic [WORD_W-1:0] srcWord, dstWord;
  logic [RULE_W-1:0] ruleWord;
  logic [REF_W-1:0]  srcRef, dstRef;
  logic              srcSlotHit, dstSlotHit, refOk, ruleFires;

  assign rdSlot   = SLOT_W'(32'(capSel) * ENTRIES + 32'(scanIdx));
  assign srcWord  = srcTab[rdSlot];
  assign dstWord  = dstTab[rdSlot];
  assign ruleWord = ruleTab[rdSlot];

  assign srcSlotHit = srcUsed[rdSlot] &&
                      prefixHit(capSrc, srcWord[WORD_W-1:LEN_W], srcWord[LEN_W-1:0]);
  assign dstSlotHit = dstUsed[rdSlot] &&
                      prefixHit(capDst, dstWord[WORD_W-1:LEN_W], dstWord[LEN_W-1:0]);

  assign srcRef = ruleWord[2*REF_W-1:REF_W];
  assign dstRef = ruleWord[REF_W-1:0];
  assign refOk  = (32'(srcRef) < ENTRIES) && (32'(dstRef) < ENTRIES);

  always_comb begin
    ruleFires = 1'b0;
    if (ruleUsed[rdSlot] && refOk)
      ruleFires = srcHit[srcRef[IDX_W-1:0]] && dstHit[dstRef[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSel   <= '0;
      capSrc   <= '0;
      capDst   <= '0;
      srcHit   <= '0;
      dstHit   <= '0;
      resValid <= 1'b0;
      resId    <= '0;
    end else begin
      resValid <= 1'b0;
      if (strobes.capture) begin
        capSel <= PSEL_W'(lkProto - PROTO_W'(1));
        capSrc <= lkSrcAddr;
        capDst <= lkDstAddr;
        srcHit <= '0;
        dstHit <= '0;
      end
      if (strobes.pfxScan) begin
        srcHit[scanIdx] <= srcSlotHit;
        dstHit[scanIdx] <= dstSlotHit;
      end
      if (strobes.ruleScan && ruleFires) begin
        resValid <= 1'b1;
        resId    <= ruleWord[RULE_W-1:2*REF_W];
      end
    end
  end

endmodule

// File: rtl/cidr_rule_matcher.sv
module cidr_rule_matcher
  import cidr_match_pkg::*;
#(
  parameter int NUM_PROTO = 4,
  parameter int ENTRIES   = 16,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrTable,
  input  logic [7:0]   wrProto,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [47:0]  wrData,
  input  logic         lkStart,
  input  logic [7:0]   lkProto,
  input  logic [31:0]  lkSrcAddr,
  input  logic [31:0]  lkDstAddr,
  output logic         lkReady,
  output logic         resValid,
  output logic [15:0]  resId,
  output logic         lkDone
);

  ctrlStrobes_t     strobes;
  logic [IDX_W-1:0] scanIdx;

  cidr_match_ctrl #(.NUM_PROTO(NUM_PROTO), .ENTRIES(ENTRIES)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .lkStart (lkStart),
    .lkProto (lkProto),
    .strobes (strobes),
    .scanIdx (scanIdx),
    .lkReady (lkReady),
    .lkDone  (lkDone)
  );

  cidr_match_dp #(.NUM_PROTO(NUM_PROTO), .ENTRIES(ENTRIES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrTable   (wrTable),
    .wrProto   (wrProto),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .lkProto   (lkProto),
    .lkSrcAddr (lkSrcAddr),
    .lkDstAddr (lkDstAddr),
    .strobes   (strobes),
    .scanIdx   (scanIdx),
    .resValid  (resValid),
    .resId     (resId)
  );

endmodule

// File: rtl/cidr_rule_matcher_chk.sv
module cidr_rule_matcher_chk #(
  parameter int NUM_PROTO = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       lkStart,
  input logic [7:0] lkProto,
  input logic       lkReady,
  input logic       resValid,
  input logic       lkDone
);

  logic goodProto;
  assign goodProto = (lkProto >= 8'd1) && (lkProto <= 8'(NUM_PROTO));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    lkDone |=> !lkDone);

  p_ready_after_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    lkDone |=> lkReady);

  p_idle_no_result_r7: assert property (@(posedge clk) disable iff (!rstN)
    lkReady |-> !resValid);

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!lkReady && !lkDone) |=> !lkReady);

  p_bad_proto_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (lkReady && lkStart && !goodProto) |=> (lkDone && !resValid));

  p_good_proto_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (lkReady && lkStart && goodProto) |=> (!lkReady && !lkDone));

endmodule

bind cidr_rule_matcher cidr_rule_matcher_chk #(.NUM_PROTO(NUM_PROTO)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .lkStart  (lkStart),
  .lkProto  (lkProto),
  .lkReady  (lkReady),
  .resValid (resValid),
  .lkDone   (lkDone)
);

// File: tb/cidr_rule_matcher_bench.sv
`timescale 1ns/1ps
module cidr_rule_matcher_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrTable = '0;
  logic [7:0]  wrProto = '0;
  logic [3:0]  wrIdx = '0;
  logic [47:0] wrData = '0;
  logic        lkStart = 1'b0;
  logic [7:0]  lkProto = '0;
  logic [31:0] lkSrcAddr = '0;
  logic [31:0] lkDstAddr = '0;
  logic        lkReady, resValid, lkDone;
  logic [15:0] resId;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cidr_rule_matcher u_cidr_rule_matcher (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrTable(wrTable), .wrProto(wrProto),
    .wrIdx(wrIdx), .wrData(wrData), .lkStart(lkStart), .lkProto(lkProto),
    .lkSrcAddr(lkSrcAddr), .lkDstAddr(lkDstAddr), .lkReady(lkReady),
    .resValid(resValid), .resId(resId), .lkDone(lkDone)
  );

  // behavioural model of table contents, indexed by protocol code 1..4
  logic [31:0] mSrcBase [1:4][16];
  int          mSrcLen  [1:4][16];
  bit          mSrcUsed [1:4][16];
  logic [31:0] mDstBase [1:4][16];
  int          mDstLen  [1:4][16];
  bit          mDstUsed [1:4][16];
  int          mRuleId  [1:4][16];
  int          mRuleS   [1:4][16];
  int          mRuleD   [1:4][16];
  bit          mRuleUsed[1:4][16];

  function automatic bit refHit(logic [31:0] a, logic [31:0] b, int len);
    int l = (len > 32) ? 32 : len;
    if (l == 0) return 1'b1;
    return (a >> (32 - l)) == (b >> (32 - l));
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(int tbl, int code, int idx, logic [47:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrTable = 2'(tbl); wrProto = 8'(code); wrIdx = 4'(idx); wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
    if (code >= 1 && code <= 4) begin
      if (tbl == 0) begin
        mSrcBase[code][idx] = data[47:16]; mSrcLen[code][idx] = int'(data[15:0]);
        mSrcUsed[code][idx] = 1'b1;
      end else if (tbl == 1) begin
        mDstBase[code][idx] = data[47:16]; mDstLen[code][idx] = int'(data[15:0]);
        mDstUsed[code][idx] = 1'b1;
      end else if (tbl == 2) begin
        mRuleId[code][idx] = int'(data[47:32]); mRuleS[code][idx] = int'(data[31:16]);
        mRuleD[code][idx] = int'(data[15:0]); mRuleUsed[code][idx] = 1'b1;
      end
    end
  endtask

  function automatic logic [47:0] pfx(logic [31:0] base, int len);
    return {base, 16'(len)};
  endfunction

  function automatic logic [47:0] rule(int id, int s, int d);
    return {16'(id), 16'(s), 16'(d)};
  endfunction

  // run one lookup; compare outputs every cycle for 36 cycles after the start edge
  task automatic lookup(string req, int code, logic [31:0] sa, logic [31:0] da,
                        bit busyPoke);
    bit expV[36];
    int expId[36];
    int doneN;
    bit good = (code >= 1 && code <= 4);
    bit sh[16];
    bit dh[16];
    foreach (expV[n]) begin expV[n] = 0; expId[n] = 0; end
    doneN = good ? 32 : 0;
    if (good) begin
      for (int i = 0; i < 16; i++) begin
        sh[i] = mSrcUsed[code][i] && refHit(sa, mSrcBase[code][i], mSrcLen[code][i]);
        dh[i] = mDstUsed[code][i] && refHit(da, mDstBase[code][i], mDstLen[code][i]);
      end
      for (int j = 0; j < 16; j++) begin
        if (mRuleUsed[code][j] && mRuleS[code][j] < 16 && mRuleD[code][j] < 16 &&
            sh[mRuleS[code][j]] && dh[mRuleD[code][j]]) begin
          expV[17 + j] = 1; expId[17 + j] = mRuleId[code][j];
        end
      end
    end
    @(negedge clk);
    lkStart = 1'b1; lkProto = 8'(code); lkSrcAddr = sa; lkDstAddr = da;
    @(negedge clk);
    lkStart = 1'b0;
    for (int n = 0; n < 36; n++) begin
      check(req, $sformatf("resValid n=%0d", n), longint'(resValid), longint'(expV[n]));
      if (expV[n]) check(req, $sformatf("resId n=%0d", n), longint'(resId), longint'(expId[n]));
      check("R7", $sformatf("lkDone n=%0d", n), longint'(lkDone), longint'(n == doneN));
      check("R7", $sformatf("lkReady n=%0d", n), longint'(lkReady), longint'(n > doneN));
      if (busyPoke && n == 5) begin
        lkStart = 1'b1; lkProto = 8'd3; lkSrcAddr = 32'h0; lkDstAddr = 32'h0;
      end else begin
        lkStart = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int p = 1; p <= 4; p++)
      for (int i = 0; i < 16; i++) begin
        mSrcUsed[p][i] = 0; mDstUsed[p][i] = 0; mRuleUsed[p][i] = 0;
        mSrcBase[p][i] = '0; mDstBase[p][i] = '0; mSrcLen[p][i] = 0; mDstLen[p][i] = 0;
        mRuleId[p][i] = 0; mRuleS[p][i] = 0; mRuleD[p][i] = 0;
      end
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "lkReady in reset", longint'(lkReady), 1);
    check("R1", "resValid in reset", longint'(resValid), 0);
    check("R1", "lkDone in reset", longint'(lkDone), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R1: empty tables give no result
    lookup("R1", 2, 32'hC0A80163, 32'h0A000005, 0);

    // TCP (2) tables, R6 layout
    doWrite(0, 2, 0, pfx(32'hC0A80100, 24));
    doWrite(0, 2, 1, pfx(32'h0A000000, 8));
    doWrite(0, 2, 2, pfx(32'h00000000, 0));
    doWrite(0, 2, 3, pfx(32'hC0A80105, 40));
    doWrite(0, 2, 4, pfx(32'h80000000, 1));
    doWrite(1, 2, 0, pfx(32'h0A000005, 32));
    doWrite(1, 2, 1, pfx(32'hAC100000, 12));
    doWrite(1, 2, 2, pfx(32'h0A000004, 31));
    doWrite(2, 2, 0, rule(4973, 0, 0));
    doWrite(2, 2, 1, rule(100, 1, 1));
    doWrite(2, 2, 2, rule(7, 2, 0));
    doWrite(2, 2, 3, rule(55, 0, 20));
    doWrite(2, 2, 4, rule(66, 5, 0));
    doWrite(2, 2, 5, rule(200, 3, 2));
    doWrite(2, 2, 6, rule(300, 4, 1));
    doWrite(2, 2, 9, rule(77, 2, 2));

    lookup("R6", 2, 32'hC0A80163, 32'h0A000005, 0);  // 4973, 7, 77
    lookup("R2", 2, 32'hC0A80105, 32'h0A000004, 0);  // len40 exact + /31
    lookup("R2", 2, 32'hC0A80106, 32'h0A000004, 0);  // len40 must not act as /31
    lookup("R4", 2, 32'h0A0A0A0A, 32'hAC1F0001, 0);  // rule 100 only
    lookup("R4", 2, 32'h7F000001, 32'h08080808, 0);  // dest misses everything
    lookup("R5", 2, 32'hC0A80101, 32'h0A000005, 0);  // index 20 and unwritten 5 stay silent
    lookup("R2", 2, 32'h80000001, 32'hAC100001, 0);  // /1 source and /12 dest

    // other protocols
    doWrite(0, 1, 0, pfx(32'h00000000, 0));
    doWrite(1, 1, 0, pfx(32'h0A000005, 32));
    doWrite(2, 1, 0, rule(900, 0, 0));
    doWrite(0, 4, 0, pfx(32'hC0000000, 2));
    doWrite(1, 4, 0, pfx(32'h00000000, 0));
    doWrite(2, 4, 0, rule(4444, 0, 0));
    lookup("R3", 1, 32'hC0A80163, 32'h0A000005, 0);
    lookup("R3", 3, 32'hC0A80163, 32'h0A000005, 0);
    lookup("R3", 4, 32'hC0A80163, 32'h0A000005, 0);

    // R8: bad protocol codes
    lookup("R8", 0, 32'hC0A80163, 32'h0A000005, 0);
    lookup("R8", 5, 32'hC0A80163, 32'h0A000005, 0);
    lookup("R8", 255, 32'hC0A80163, 32'h0A000005, 0);

    // R9: start pulsed mid-lookup
    lookup("R9", 2, 32'hC0A80163, 32'h0A000005, 1);

    // R10: writes that must be dropped
    doWrite(0, 0, 0, pfx(32'h00000000, 0));
    doWrite(2, 5, 1, rule(999, 0, 0));
    doWrite(3, 2, 7, rule(111, 2, 0));
    doWrite(2, 0, 1, rule(888, 0, 0));
    lookup("R10", 4, 32'h7F000001, 32'h0A000005, 0);
    lookup("R10", 1, 32'hC0A80163, 32'h0A000005, 0);
    lookup("R10", 2, 32'hC0A80163, 32'h0A000005, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule